// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

This block is a byte-wide serial shift register paired with an edge counter. Together they form a three-wire synchronous serial port with a data input, a data output and a serial clock, and it follows SPI data modes 0 and 1. There is no chip-select handling. The port can act as the clock master or as a clock follower. As master, software writes a toggle strobe that inverts the clock pin. As follower, the clock pin is taken from outside through a synchronizer. The counter advances on both clock edges, so one byte takes sixteen counted edges. The wrap of the counter raises a sticky overflow flag that marks the end of the transfer.

The register shifts MSB first. Its top bit reaches the data-out pin through an output latch. Two master units wired as a ring exchange their register contents after eight clock periods. A second strobe can clock the shifter directly, one shift per strobe, with the counter still driven by the toggle strobe. This allows a transfer at half the system clock rate. Software loads the transmit byte, clears the flag and zeroes the counter before a transfer. It reads the received byte from the same register once the flag is set.

Top module: `tw_shift_unit`

## Requirements
- R1: After reset, `sdo_pin`, `sck_out`, `ovf_flag` and `rx_data` are all 0, and the edge counter is 0.
- R2: Each cycle with `tgl_stb` high inverts `sck_out` at the next clock edge. Without `tgl_stb`, `sck_out` holds its value.
- R3: The counter adds one for each counted clock edge, both rising and falling. When it wraps from 15 to 0 it sets `ovf_flag`, so sixteen edges from zero (eight full clock periods) set the flag, and fifteen do not.
- R4: `ovf_flag` stays set until a cycle with `ovf_clr` high clears it. If a wrap and `ovf_clr` fall in the same cycle, the flag ends set.
- R5: A cycle with `cnt_wr` high loads `cnt_wdata` into the counter, and this takes priority over counting. A load of 14 followed by two counted edges sets the flag, and one edge does not.
- R6: `dr_wr` loads `dr_wdata` into the register and sets `sdo_pin` to bit 7 of `dr_wdata`. With `edge_mode` = 0, a rising clock edge shifts `sdi_pin` into bit 0, with the MSB going out first. A falling edge copies the new bit 7 to `sdo_pin`.
- R7: With `edge_mode` = 1 the edges swap roles: a falling edge samples and shifts, and a rising edge updates `sdo_pin`.
- R8: With `clk_sel` = 2'b10 or 2'b11 (external), edges come from `sck_pin_in` through a two-flop synchronizer and an edge detector. In this mode `tgl_stb` neither counts nor shifts.
- R9: With `clk_sel` = 2'b01 (strobe), each `shf_stb` shifts `sdi_pin` in once and moves the new bit 7 to `sdo_pin` in the same cycle. `tgl_stb` still toggles the clock and counts, but clock edges do not shift.
- R10: With `clk_sel` = 2'b00 (toggle), after eight full clock periods started from a low clock, `rx_data` holds the byte the peer sent, and the peer has received the loaded byte bit by bit, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dr_wr | input | 1 | Load the data register |
| dr_wdata | input | 8 | Byte to transmit |
| cnt_wr | input | 1 | Load the edge counter |
| cnt_wdata | input | 4 | Counter load value |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| clk_sel | input | 2 | 00 toggle, 01 strobe, 1x external |
| edge_mode | input | 1 | 0: sample rising, 1: sample falling |
| tgl_stb | input | 1 | Clock toggle strobe |
| shf_stb | input | 1 | Direct shift strobe (strobe source only) |
| sdi_pin | input | 1 | Serial data in level |
| sck_pin_in | input | 1 | External serial clock level |
| sdo_pin | output | 1 | Serial data out level |
| sck_out | output | 1 | Serial clock drive |
| ovf_flag | output | 1 | Transfer complete flag |
| rx_data | output | 8 | Data register contents |

## Verification
The case hardest to reach from the ports is the follower path. There, every edge arrives three system cycles after the pin moves, and the data input must stay steady across that delay. The bench drives `sck_pin_in` with eight-cycle half periods and changes `sdi_pin` only right after a falling level. It checks `sdo_pin` late in each phase. Coincident events are forced by placing a wrap and a flag clear in the same strobe cycle, and by issuing toggles while the external source is selected with the counter preloaded to 15.

// File: rtl/tws_pkg.sv
// Package: shared encodings for the three-wire shift unit.
// Assumes: clk_sel values 2 and 3 both mean the external clock pin.
package tws_pkg;
    typedef enum logic [1:0] {
        SRC_TOGGLE = 2'b00,
        SRC_STROBE = 2'b01,
        SRC_EXT_A  = 2'b10,
        SRC_EXT_B  = 2'b11
    } clk_src_e;
endpackage

// File: rtl/tws_edge_src.sv
// Edge source: makes the master clock from the toggle strobe, synchronizes the
// external clock pin, and turns the selected clock into counted, sampling and
// changing edge pulses.
// Assumes: SYNC_STAGES >= 2, and the external pin holds each level for more
// than SYNC_STAGES + 1 system cycles.
module tws_edge_src
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel,
    input  logic       edge_mode,
    input  logic       tgl_stb,
    input  logic       sck_pin_in,
    output logic       sck_out,
    output logic       cnt_edge,
    output logic       sample_edge,
    output logic       change_edge
);
    logic                   sck_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   ext_sel, stb_sel;
    logic                   rise, fall;

    // Master clock level: invert on every toggle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       sck_q <= 1'b0;
        else if (tgl_stb) sck_q <= ~sck_q;
    end

    // Synchronizer chain for the external clock pin.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= sck_pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronized level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Pick the edge source and classify each edge.
    always_comb begin
        ext_sel = clk_sel[1];
        stb_sel = (clk_src_e'(clk_sel) == SRC_STROBE);
        if (ext_sel) begin
            rise = sync_q[SYNC_STAGES-1] & ~prev_q;
            fall = ~sync_q[SYNC_STAGES-1] & prev_q;
        end else begin
            rise = tgl_stb & ~sck_q;
            fall = tgl_stb & sck_q;
        end
        cnt_edge    = rise | fall;
        sample_edge = ~stb_sel & (edge_mode ? fall : rise);
        change_edge = ~stb_sel & (edge_mode ? rise : fall);
    end

    assign sck_out = sck_q;
endmodule

// File: rtl/tws_shifter.sv
// Shifter: the data register, shifting MSB first, plus the output latch that
// drives the data-out pin.
// Assumes: DATA_W >= 2; a register write wins over a strobe shift, and a strobe
// shift wins over edge actions.
module tws_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dr_wr,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic              stb_shift,
    input  logic              sample_edge,
    input  logic              change_edge,
    input  logic              sdi,
    output logic [DATA_W-1:0] dr,
    output logic              sdo
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] dr_q;
    logic              sdo_q;

    // Data register: load, or shift the input bit into bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                       dr_q <= '0;
        else if (dr_wr)                   dr_q <= dr_wdata;
        else if (stb_shift | sample_edge) dr_q <= {dr_q[MSB-1:0], sdi};
    end

    // Output latch: follows the register MSB on change edges and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)           sdo_q <= 1'b0;
        else if (dr_wr)       sdo_q <= dr_wdata[MSB];
        else if (stb_shift)   sdo_q <= dr_q[MSB-1];
        else if (change_edge) sdo_q <= dr_q[MSB];
    end

    assign dr  = dr_q;
    assign sdo = sdo_q;
endmodule

// File: rtl/tws_edge_counter.sv
// Edge counter: counts clock edges and sets a sticky flag on wrap.
// Assumes: 2**CNT_W edges make one transfer; a load wins over counting, and
// setting the flag wins over clearing it.
module tws_edge_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             edge_in,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             wrap;

    // A counted edge at the top value wraps the counter.
    assign wrap = ~cnt_wr & edge_in & (&cnt_q);

    // Counter: load or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_wr)  cnt_q <= cnt_wdata;
        else if (edge_in) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky flag: set on wrap, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (wrap)    ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    assign cnt = cnt_q;
    assign ovf = ovf_q;
endmodule

// File: rtl/tw_shift_unit.sv
// Top: three-wire serial shift unit. Connects the edge source, the shifter and
// the edge counter.
// Assumes: 2*DATA_W is a power of two, so the counter wraps once per byte.
module tw_shift_unit
    import tws_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(2 * DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dr_wr,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              ovf_clr,
    input  logic [1:0]        clk_sel,
    input  logic              edge_mode,
    input  logic              tgl_stb,
    input  logic              shf_stb,
    input  logic              sdi_pin,
    input  logic              sck_pin_in,
    output logic              sdo_pin,
    output logic              sck_out,
    output logic              ovf_flag,
    output logic [DATA_W-1:0] rx_data
);
    logic             cnt_edge, sample_edge, change_edge, stb_shift;
    logic [CNT_W-1:0] cnt_q;

    // Direct shift strobe acts only when the strobe source is selected.
    assign stb_shift = shf_stb & (clk_src_e'(clk_sel) == SRC_STROBE);

    tws_edge_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .edge_mode(edge_mode),
        .tgl_stb(tgl_stb), .sck_pin_in(sck_pin_in), .sck_out(sck_out),
        .cnt_edge(cnt_edge), .sample_edge(sample_edge), .change_edge(change_edge)
    );

    tws_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .dr_wr(dr_wr), .dr_wdata(dr_wdata),
        .stb_shift(stb_shift), .sample_edge(sample_edge),
        .change_edge(change_edge), .sdi(sdi_pin), .dr(rx_data), .sdo(sdo_pin)
    );

    tws_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .edge_in(cnt_edge), .ovf_clr(ovf_clr), .cnt(cnt_q), .ovf(ovf_flag)
    );
endmodule

// File: rtl/tws_checker.sv
// Checker: temporal properties of the three-wire shift unit, bound to the top.
module tws_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tgl_stb,
    input logic              sck_out,
    input logic              ovf_clr,
    input logic              ovf_flag,
    input logic              cnt_wr,
    input logic [CNT_W-1:0]  cnt_wdata,
    input logic [CNT_W-1:0]  cnt,
    input logic              dr_wr,
    input logic [DATA_W-1:0] dr_wdata,
    input logic [DATA_W-1:0] rx_data,
    input logic              sdo_pin
);
    p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tgl_stb |=> sck_out != $past(sck_out));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tgl_stb |=> $stable(sck_out));
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt) == {CNT_W{1'b1}} && cnt == '0));
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt == $past(cnt_wdata));
    p_dr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dr_wr |=> (rx_data == $past(dr_wdata) && sdo_pin == $past(dr_wdata[DATA_W-1])));
endmodule

bind tw_shift_unit tws_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tgl_stb(tgl_stb), .sck_out(sck_out),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .cnt(cnt_q), .dr_wr(dr_wr), .dr_wdata(dr_wdata),
    .rx_data(rx_data), .sdo_pin(sdo_pin)
);

// File: tb/sim_tw_shift_unit.sv
module sim_tw_shift_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dr_wr = 0, cnt_wr = 0, ovf_clr = 0, edge_mode = 0;
    logic       tgl_stb = 0, shf_stb = 0, sdi_pin = 0, sck_pin_in = 0;
    logic [7:0] dr_wdata = 0;
    logic [3:0] cnt_wdata = 0;
    logic [1:0] clk_sel = 2'b00;
    logic       sdo_pin, sck_out, ovf_flag;
    logic [7:0] rx_data;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tw_shift_unit u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic sh);
        @(negedge clk); tgl_stb = 1; shf_stb = sh;
        @(negedge clk); tgl_stb = 0; shf_stb = 0;
    endtask

    // Clear flag, zero counter, load transmit byte.
    task automatic prepare(input logic [7:0] b);
        @(negedge clk); ovf_clr = 1; cnt_wr = 1; cnt_wdata = 0; dr_wr = 1; dr_wdata = b;
        @(negedge clk); ovf_clr = 0; cnt_wr = 0; dr_wr = 0;
    endtask

    task automatic t_reset;
        check("R1 sdo", sdo_pin, 0);
        check("R1 sck", sck_out, 0);
        check("R1 ovf", ovf_flag, 0);
        check("R1 rx", rx_data, 0);
    endtask

    task automatic t_master(input logic mode, input logic [7:0] mst, input logic [7:0] slv);
        string rq = mode ? "R7" : "R6";
        clk_sel = 2'b00; edge_mode = mode;
        prepare(mst);
        check("R2 idle clock low", sck_out, 0);
        for (int i = 7; i >= 0; i--) begin
            if (!mode) begin
                sdi_pin = slv[i];
                check(rq, sdo_pin, mst[i]);
                pulse(0);
                check("R2 toggled high", sck_out, 1);
                if (i == 0) check("R3 no wrap at 15", ovf_flag, 0);
                pulse(0);
            end else begin
                pulse(0);
                check(rq, sdo_pin, mst[i]);
                sdi_pin = slv[i];
                if (i == 0) check("R3 no wrap at 15", ovf_flag, 0);
                pulse(0);
            end
        end
        check("R3 wrap after 16", ovf_flag, 1);
        check("R10 received", rx_data, slv);
    endtask

    task automatic t_counter;
        clk_sel = 2'b00; edge_mode = 0;
        tick(5);
        check("R4 sticky", ovf_flag, 1);
        @(negedge clk); ovf_clr = 1;
        @(negedge clk); ovf_clr = 0;
        check("R4 cleared", ovf_flag, 0);
        @(negedge clk); cnt_wr = 1; cnt_wdata = 4'd14;
        @(negedge clk); cnt_wr = 0;
        pulse(0);
        check("R5 load 14 plus one", ovf_flag, 0);
        pulse(0);
        check("R5 load 14 plus two", ovf_flag, 1);
        @(negedge clk); ovf_clr = 1; cnt_wr = 1; cnt_wdata = 4'd15;
        @(negedge clk); ovf_clr = 0; cnt_wr = 0;
        @(negedge clk); tgl_stb = 1; ovf_clr = 1;
        @(negedge clk); tgl_stb = 0; ovf_clr = 0;
        check("R4 set wins over clear", ovf_flag, 1);
        pulse(0);
    endtask

    task automatic t_ext(input logic [7:0] mst, input logic [7:0] slv);
        clk_sel = 2'b10; edge_mode = 0;
        prepare(slv);
        for (int i = 7; i >= 0; i--) begin
            sdi_pin = mst[i];
            check("R8 slave out", sdo_pin, slv[i]);
            sck_pin_in = 1; tick(8);
            sck_pin_in = 0; tick(8);
        end
        check("R8 received", rx_data, mst);
        check("R8 wrap", ovf_flag, 1);
        @(negedge clk); ovf_clr = 1; cnt_wr = 1; cnt_wdata = 4'd15;
        @(negedge clk); ovf_clr = 0; cnt_wr = 0;
        pulse(0); pulse(0);
        check("R8 toggle ignored flag", ovf_flag, 0);
        check("R8 toggle ignored data", rx_data, mst);
        sck_pin_in = 1; tick(6);
        check("R8 pin edge counts", ovf_flag, 1);
        sck_pin_in = 0; tick(6);
    endtask

    task automatic t_strobe(input logic [7:0] mst, input logic [7:0] slv);
        clk_sel = 2'b01; edge_mode = 0;
        prepare(mst);
        for (int i = 7; i >= 0; i--) begin
            sdi_pin = slv[i];
            check("R9 out", sdo_pin, mst[i]);
            pulse(0);
            check("R9 no shift on edge", rx_data[0], (i == 7) ? mst[0] : slv[i+1]);
            pulse(1);
        end
        check("R9 received", rx_data, slv);
        check("R9 wrap", ovf_flag, 1);
    endtask

    initial begin
        fork
            begin
                tick(3); rst_n = 1; tick(1);
                t_reset();
                t_master(0, 8'hA5, 8'h3C);
                t_counter();
                t_master(1, 8'h96, 8'hE1);
                t_master(0, 8'h01, 8'h80);
                t_ext(8'h5B, 8'hC6);
                t_strobe(8'h72, 8'h9D);
                done = 1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_chk++; n_fail++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule